// File: doc/BRIEF.md
# Dual-Polarity Reset Sequencer

This block turns two asynchronous reset pins of opposite polarity into one clean internal reset and a start strobe for the core. One pin resets when driven low and the other when driven high; asserting either one alone is enough. Each pin first passes through its own two-flop synchronizer.

A pulse-width filter then counts the consecutive clock cycles in which a synchronized request is active. The internal reset is only taken after six such cycles, so shorter glitches on the pins do not disturb a running core.

Once in reset, the internal reset is held for as long as any request stays active. After the last request goes away, a countdown of sixteen cycles runs. At its end, the internal reset drops and a single-cycle fetch-enable pulse tells the core to fetch its first instruction. Any request seen during the countdown sends the sequencer back to hold, and the countdown starts over.

Top module: `resetSequencer`

## Requirements
- R1: Each pin is sampled by a two-stage synchronizer, so a pin change reaches the sequencing logic two clock edges after the first edge that samples it.
- R2: Holding `nResetPin` low for 6 consecutive sampled cycles asserts `coreRst`; it reads 1 after the 8th rising edge following the first edge that samples the pin low, and 0 after the 7th.
- R3: Holding `resetPin` high for 6 consecutive sampled cycles asserts `coreRst` with the same 8-edge timing as R2.
- R4: A request lasting fewer than 6 consecutive sampled cycles leaves `coreRst` and `fetchGo` at 0. This includes two short pulses separated by a one-cycle gap.
- R5: While either pin stays asserted, `coreRst` stays 1, whichever pin was asserted first or released last.
- R6: After the last asserted pin is released, `fetchGo` reads 1 for one cycle after the 18th rising edge. That edge is the first that samples the released level, plus 2 synchronizer edges, plus 16. `coreRst` falls to 0 on the same edge.
- R7: `fetchGo` is never 1 while `coreRst` is 1.
- R8: Any request seen during the 16-cycle countdown, even a single cycle long, keeps `coreRst` at 1 and restarts the countdown. The full 18-edge delay of R6 is then measured from the end of that request.
- R9: `fetchGo` returns to 0 on the edge after its pulse and stays 0 until the next reset sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| nResetPin | input | 1 | Asynchronous reset request, active low |
| resetPin | input | 1 | Asynchronous reset request, active high |
| coreRst | output | 1 | Synchronous internal reset, active high |
| fetchGo | output | 1 | One-cycle strobe that releases the first instruction fetch |

## Verification
The bench aims at the boundaries of the width filter:
- A five-cycle pulse on each pin, and two three-cycle pulses split by a one-cycle gap, both of which must be ignored. A filter that counted non-consecutive cycles, or had an off-by-one limit, would reset the core on them.
- An exact six-cycle pulse, which must reset. A filter one count too strict would miss it.

The bench also overlaps the two pins, releasing them in reverse order. A design that tracked only one input would release the core 18 cycles after the first release instead of the last.

Finally, the bench injects a one-cycle request in the middle of the countdown. A sequencer that ignored it would fire `fetchGo` at the original time. One that demanded a full six-cycle pulse to re-enter hold would do the same.

// File: rtl/rstSeqPkg.sv
package rstSeqPkg;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_COUNT = 2'd2
  } seqState_t;

  // strobes from the control FSM into the counter datapath
  typedef struct packed {
    logic clrWidth;
    logic incWidth;
    logic loadDelay;
    logic incDelay;
  } seqStrobes_t;

  // compare results from the datapath back to the FSM
  typedef struct packed {
    logic widthHit;
    logic delayHit;
  } seqFlags_t;

endpackage

// File: rtl/resetSyncChain.sv
module resetSyncChain #(
  parameter int STAGES     = 2,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic pinIn,
  output logic reqOut
);

  logic [STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    syncQ <= {syncQ[STAGES-2:0], pinIn};
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign reqOut = ~syncQ[STAGES-1];
    end else begin : g_high
      assign reqOut = syncQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/resetDatapath.sv
module resetDatapath
  import rstSeqPkg::*;
#(
  parameter int MIN_PULSE   = 6,
  parameter int FETCH_DELAY = 16
) (
  input  logic        clk,
  input  seqStrobes_t strobes,
  output seqFlags_t   flags
);

  localparam int WIDTH_W = $clog2(MIN_PULSE + 1);
  localparam int DELAY_W = $clog2(FETCH_DELAY + 1);
  localparam logic [WIDTH_W-1:0] WIDTH_LAST = WIDTH_W'(MIN_PULSE - 1);
  localparam logic [DELAY_W-1:0] DELAY_LAST = DELAY_W'(FETCH_DELAY - 1);

  logic [WIDTH_W-1:0] widthCnt;
  logic [DELAY_W-1:0] delayCnt;

  // consecutive active-request cycles seen while running
  always_ff @(posedge clk) begin
    if (strobes.clrWidth) begin
      widthCnt <= '0;
    end else if (strobes.incWidth && (widthCnt != WIDTH_LAST)) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  // cycles elapsed since the synchronized release
  always_ff @(posedge clk) begin
    if (strobes.loadDelay) begin
      delayCnt <= DELAY_W'(1);
    end else if (strobes.incDelay) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  assign flags.widthHit = (widthCnt == WIDTH_LAST);
  assign flags.delayHit = (delayCnt == DELAY_LAST);

endmodule

// File: rtl/resetControl.sv
module resetControl
  import rstSeqPkg::*;
(
  input  logic        clk,
  input  logic        reqAny,
  input  seqFlags_t   flags,
  output seqStrobes_t strobes,
  output logic        coreRst,
  output logic        fetchGo
);

  seqState_t state;

  always_comb begin
    strobes = '0;
    unique case (state)
      SEQ_RUN: begin
        strobes.incWidth = reqAny;
        strobes.clrWidth = ~reqAny;
      end
      SEQ_HOLD: begin
        strobes.clrWidth  = 1'b1;
        strobes.loadDelay = ~reqAny;
      end
      SEQ_COUNT: begin
        strobes.clrWidth = 1'b1;
        strobes.incDelay = ~reqAny & ~flags.delayHit;
      end
      default: strobes.clrWidth = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    fetchGo <= 1'b0;
    unique case (state)
      SEQ_RUN: begin
        if (reqAny && flags.widthHit) begin
          state   <= SEQ_HOLD;
          coreRst <= 1'b1;
        end
      end
      SEQ_HOLD: begin
        if (!reqAny) begin
          state <= SEQ_COUNT;
        end
      end
      SEQ_COUNT: begin
        if (reqAny) begin
          state <= SEQ_HOLD;
        end else if (flags.delayHit) begin
          state   <= SEQ_RUN;
          coreRst <= 1'b0;
          fetchGo <= 1'b1;
        end
      end
      default: begin
        state   <= SEQ_HOLD;
        coreRst <= 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/resetSequencer.sv
module resetSequencer
  import rstSeqPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_PULSE     = 6,
  parameter int FETCH_DELAY   = 16,
  parameter bit HIGH_PIN_USED = 1'b1
) (
  input  logic clk,
  input  logic nResetPin,
  input  logic resetPin,
  output logic coreRst,
  output logic fetchGo
);

  logic        reqLow;
  logic        reqHigh;
  logic        reqAny;
  seqStrobes_t strobes;
  seqFlags_t   flags;

  resetSyncChain #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) i_syncLow (
    .clk   (clk),
    .pinIn (nResetPin),
    .reqOut(reqLow)
  );

  generate
    if (HIGH_PIN_USED) begin : g_highPin
      resetSyncChain #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b0)) i_syncHigh (
        .clk   (clk),
        .pinIn (resetPin),
        .reqOut(reqHigh)
      );
    end else begin : g_noHighPin
      assign reqHigh = 1'b0;
    end
  endgenerate

  assign reqAny = reqLow | reqHigh;

  resetDatapath #(.MIN_PULSE(MIN_PULSE), .FETCH_DELAY(FETCH_DELAY)) i_datapath (
    .clk    (clk),
    .strobes(strobes),
    .flags  (flags)
  );

  resetControl i_control (
    .clk    (clk),
    .reqAny (reqAny),
    .flags  (flags),
    .strobes(strobes),
    .coreRst(coreRst),
    .fetchGo(fetchGo)
  );

endmodule

// File: rtl/resetSequencerChecks.sv
module resetSequencerChecks #(
  parameter int MIN_PULSE   = 6,
  parameter int FETCH_DELAY = 16
) (
  input logic clk,
  input logic reqAny,
  input logic coreRst,
  input logic fetchGo
);

  localparam int ACT_W = $clog2(MIN_PULSE + 2);
  localparam int QUI_W = $clog2(FETCH_DELAY + 2);
  localparam logic [ACT_W-1:0] ACT_MAX = ACT_W'(MIN_PULSE + 1);
  localparam logic [QUI_W-1:0] QUI_MAX = QUI_W'(FETCH_DELAY + 1);

  logic             primed;
  logic [ACT_W-1:0] activeCnt;
  logic [QUI_W-1:0] quietCnt;

  always_ff @(posedge clk) begin
    primed <= primed | coreRst;
    if (reqAny) begin
      quietCnt  <= '0;
      activeCnt <= (activeCnt == ACT_MAX) ? activeCnt : activeCnt + 1'b1;
    end else begin
      activeCnt <= '0;
      quietCnt  <= (quietCnt == QUI_MAX) ? quietCnt : quietCnt + 1'b1;
    end
  end

  assert_min_width_R4: assert property (@(posedge clk) disable iff (!primed)
    $rose(coreRst) |-> (activeCnt == ACT_W'(MIN_PULSE)));

  assert_hold_while_req_R5: assert property (@(posedge clk) disable iff (!primed)
    (reqAny && coreRst) |=> coreRst);

  assert_release_delay_R6: assert property (@(posedge clk) disable iff (!primed)
    fetchGo |-> (quietCnt == QUI_W'(FETCH_DELAY)) && $past(coreRst));

  assert_no_fetch_in_reset_R7: assert property (@(posedge clk) disable iff (!primed)
    fetchGo |-> !coreRst);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!primed)
    fetchGo |=> !fetchGo);

  assert_no_spontaneous_reset_R4: assert property (@(posedge clk) disable iff (!primed)
    (!coreRst && !reqAny) |=> !coreRst);

endmodule

bind resetSequencer resetSequencerChecks #(
  .MIN_PULSE  (MIN_PULSE),
  .FETCH_DELAY(FETCH_DELAY)
) i_checks (
  .clk    (clk),
  .reqAny (reqAny),
  .coreRst(coreRst),
  .fetchGo(fetchGo)
);

// File: tb/test_resetSequencer.sv
module test_resetSequencer;

  logic clk = 1'b0;
  logic nResetPin;
  logic resetPin;
  logic coreRst;
  logic fetchGo;

  int  cyc = 0;
  int  vectors = 0;
  int  misses = 0;
  bit  done = 1'b0;

  typedef struct {
    int    cycle;
    logic  rst;
    logic  fg;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t item;

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  resetSequencer i_resetSequencer (
    .clk      (clk),
    .nResetPin(nResetPin),
    .resetPin (resetPin),
    .coreRst  (coreRst),
    .fetchGo  (fetchGo)
  );

  // scoreboard driver side: queue an expected output pair for an absolute cycle
  task automatic expectAt(input int when, input logic r, input logic f, input string tag);
    expItem_t e;
    e.cycle = when;
    e.rst   = r;
    e.fg    = f;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  task automatic stepTo(input int when);
    while (cyc < when) @(negedge clk);
  endtask

  // scoreboard monitor side: compare at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cycle <= cyc) begin
      item = expQ.pop_front();
      vectors++;
      if (item.cycle != cyc || coreRst !== item.rst || fetchGo !== item.fg) begin
        misses++;
        $display("FAIL %s cycle %0d: coreRst=%b fetchGo=%b, expected coreRst=%b fetchGo=%b",
                 item.tag, item.cycle, coreRst, fetchGo, item.rst, item.fg);
      end
    end
  end

  initial begin
    nResetPin = 1'b0;
    resetPin  = 1'b0;
    // reset state while the low pin is held
    expectAt(12, 1'b1, 1'b0, "R2");
    expectAt(19, 1'b1, 1'b0, "R7");
    stepTo(20);

    // R1 R6 R9: release of the low pin, 2 sync edges + 16
    nResetPin = 1'b1;
    expectAt(37, 1'b1, 1'b0, "R6");
    expectAt(38, 1'b0, 1'b1, "R1 R6");
    expectAt(39, 1'b0, 1'b0, "R9");
    expectAt(50, 1'b0, 1'b0, "R9");
    stepTo(60);

    // R4: five-cycle low pulse ignored
    expectAt(68, 1'b0, 1'b0, "R4");
    expectAt(75, 1'b0, 1'b0, "R4");
    expectAt(85, 1'b0, 1'b0, "R4");
    nResetPin = 1'b0;
    stepTo(65);
    nResetPin = 1'b1;
    stepTo(90);

    // R4: five-cycle high pulse ignored
    expectAt(98, 1'b0, 1'b0, "R4");
    expectAt(105, 1'b0, 1'b0, "R4");
    resetPin = 1'b1;
    stepTo(95);
    resetPin = 1'b0;
    stepTo(110);

    // R2: exactly six cycles low resets
    expectAt(117, 1'b0, 1'b0, "R2");
    expectAt(118, 1'b1, 1'b0, "R1 R2");
    expectAt(133, 1'b1, 1'b0, "R6");
    expectAt(134, 1'b0, 1'b1, "R6");
    expectAt(135, 1'b0, 1'b0, "R9");
    nResetPin = 1'b0;
    stepTo(116);
    nResetPin = 1'b1;
    stepTo(150);

    // R3: high pin for eight cycles
    expectAt(157, 1'b0, 1'b0, "R3");
    expectAt(158, 1'b1, 1'b0, "R3");
    expectAt(175, 1'b1, 1'b0, "R3");
    expectAt(176, 1'b0, 1'b1, "R3");
    expectAt(177, 1'b0, 1'b0, "R9");
    resetPin = 1'b1;
    stepTo(158);
    resetPin = 1'b0;
    stepTo(190);

    // R5: overlapping pins, released in reverse order
    expectAt(198, 1'b1, 1'b0, "R5");
    expectAt(215, 1'b1, 1'b0, "R5");
    expectAt(228, 1'b1, 1'b0, "R5");
    expectAt(237, 1'b1, 1'b0, "R5");
    expectAt(238, 1'b0, 1'b1, "R5");
    nResetPin = 1'b0;
    stepTo(200);
    resetPin = 1'b1;
    stepTo(210);
    nResetPin = 1'b1;
    stepTo(220);
    resetPin = 1'b0;
    stepTo(250);

    // R8: one-cycle request during the countdown restarts it
    expectAt(258, 1'b1, 1'b0, "R8");
    expectAt(278, 1'b1, 1'b0, "R8");
    expectAt(288, 1'b1, 1'b0, "R8");
    expectAt(289, 1'b0, 1'b1, "R8");
    expectAt(290, 1'b0, 1'b0, "R9");
    nResetPin = 1'b0;
    stepTo(260);
    nResetPin = 1'b1;
    stepTo(270);
    resetPin = 1'b1;
    stepTo(271);
    resetPin = 1'b0;
    stepTo(300);

    // R4: two three-cycle pulses with a one-cycle gap are not consecutive
    expectAt(310, 1'b0, 1'b0, "R4");
    expectAt(315, 1'b0, 1'b0, "R4");
    expectAt(330, 1'b0, 1'b0, "R4");
    nResetPin = 1'b0;
    stepTo(303);
    nResetPin = 1'b1;
    stepTo(304);
    nResetPin = 1'b0;
    stepTo(307);
    nResetPin = 1'b1;
    stepTo(340);

    while (expQ.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, actual cycle %0d expected under 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule